// File: doc/BRIEF.md
# I2C register-pointer target

This block is a serial-bus target for an open-drain two-wire bus (clock and data). It watches the bus for START and STOP conditions and compares the first byte of each transaction with its own 7-bit address. The upper five address bits are a parameter and the lower two come from strap pins. Once selected, it gives the bus host access to a small register file that sits outside the block, through an internal pointer register. Both bus lines pass through a synchronizer and are sampled on the system clock. The block answers only by pulling the data line low through an output-enable.

A write transaction loads the pointer with its first byte. It may then carry one more byte, which is written to the register the pointer selects. A read transaction returns exactly one byte from the pointed register, most significant bit first. The host then ends the read with a not-acknowledge and a STOP. Neither path advances the pointer. Any byte past the allowed count is left unacknowledged and changes nothing.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset the target does not drive the data line (`sda_oe` = 0), `rf_we` is 0 and the pointer `rf_addr` is 0.
- R2: The first byte after START is {DEV_HI[4:0], pin_a[1:0], rw}, sent MSB first, where rw = 1 means read. When the seven address bits match, the target pulls the data line low during the ninth clock of that byte.
- R3: On an address mismatch the target sends no acknowledge and does not drive the data line until the next START. Later bytes in that transaction change neither the pointer nor any register.
- R4: In a write (rw = 0), the first byte after the address is acknowledged, and its low REG_AW bits become the pointer, visible on `rf_addr`.
- R5: A second byte in a write is acknowledged and produces exactly one single-cycle `rf_we` pulse, with `rf_addr` equal to the pointer and `rf_wdata` equal to the byte. The pulse falls while the clock line is low.
- R6: A third or later byte in a write is not acknowledged and produces no `rf_we` pulse.
- R7: In a read (rw = 1), the target shifts out `rf_rdata` at the pointer, MSB first, changing the data line only while the clock line is low. The pointer does not change.
- R8: The target releases the data line for the ninth clock of the read byte. It sends nothing more in that transaction, whether the host acknowledges or not.
- R9: A repeated START in the middle of a transaction restarts address matching, so a write of the pointer followed by a repeated START and a read returns the byte at the new pointer.
- R10: A STOP returns the target to idle. Bytes clocked after a STOP without a new START are not acknowledged.
- R11: Changing `pin_a` moves the address the target answers to. The old address then gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| pin_a | input | 2 | Strap pins giving the two low address bits |
| rf_addr | output | REG_AW | Register-file address, equal to the pointer |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Single-cycle register-file write strobe |
| rf_rdata | input | 8 | Register-file read data at `rf_addr` |

## Verification
The bench builds the target with REG_AW = 4 and keeps the default device-address pattern and a two-stage synchronizer. The narrow pointer means a pointer byte such as 0x3A must land on register 0xA, so truncation of the pointer byte is checked. It also lets the bench compare the whole 16-entry register file after every transaction. The strap pins are switched during the run, so both address matches and address mismatches are reached against the same parameter set.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_SKIP
   } phase_e;

endpackage

// File: rtl/i2c_ptr_sync.sv
module i2c_ptr_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '1;
            else        stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '1;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/i2c_ptr_cond.sv
module i2c_ptr_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_ptr_engine.sv
module i2c_ptr_engine
   import i2c_ptr_pkg::*;
#(
   parameter logic [4:0]  DEV_HI = 5'b01011,
   parameter int unsigned REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              sda_s,
   input  logic [1:0]        pin_a,
   input  logic [BYTE_W-1:0] rf_rdata,
   output logic              sda_oe,
   output logic [REG_AW-1:0] ptr,
   output logic [BYTE_W-1:0] rf_wdata,
   output logic              rf_we,
   output logic              matched
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   phase_e            ph_q;
   logic [BYTE_W-1:0] sh_q;
   logic [CNT_W-1:0]  bit_q;
   logic [1:0]        idx_q;
   logic              rd_q;
   logic              take_byte;

   // idx 0: address byte, 1: pointer byte, 2: data byte, 3: surplus
   always_comb begin
      unique case (idx_q)
         2'd0:    take_byte = (sh_q[7:1] == {DEV_HI, pin_a});
         2'd1:    take_byte = ~rd_q;
         2'd2:    take_byte = ~rd_q;
         default: take_byte = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         sh_q    <= '0;
         bit_q   <= '0;
         idx_q   <= '0;
         rd_q    <= 1'b0;
         sda_oe  <= 1'b0;
         ptr     <= '0;
         rf_we   <= 1'b0;
         matched <= 1'b0;
      end else begin
         rf_we <= 1'b0;
         if (start_p) begin
            ph_q    <= PH_RX;
            bit_q   <= '0;
            idx_q   <= '0;
            sda_oe  <= 1'b0;
            matched <= 1'b0;
         end else if (stop_p) begin
            ph_q    <= PH_IDLE;
            sda_oe  <= 1'b0;
            matched <= 1'b0;
         end else begin
            unique case (ph_q)
               PH_RX: begin
                  if (scl_rise && bit_q != FULL) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall && bit_q == FULL) begin
                     if (take_byte) begin
                        ph_q   <= PH_ACK;
                        sda_oe <= 1'b1;
                        idx_q  <= (idx_q == 2'd3) ? idx_q : idx_q + 2'd1;
                        if (idx_q == 2'd0) begin
                           rd_q    <= sh_q[0];
                           matched <= 1'b1;
                        end
                        if (idx_q == 2'd1) ptr   <= sh_q[REG_AW-1:0];
                        if (idx_q == 2'd2) rf_we <= 1'b1;
                     end else begin
                        ph_q <= PH_SKIP;
                     end
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (rd_q) begin
                        ph_q   <= PH_TX;
                        sh_q   <= rf_rdata;
                        sda_oe <= ~rf_rdata[BYTE_W-1];
                     end else begin
                        ph_q   <= PH_RX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (bit_q == LAST) begin
                        ph_q   <= PH_SKIP;
                        sda_oe <= 1'b0;
                     end else begin
                        sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sh_q[BYTE_W-2];
                        bit_q  <= bit_q + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rf_wdata = sh_q;

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
   import i2c_ptr_pkg::*;
#(
   parameter logic [4:0]  DEV_HI      = 5'b01011,
   parameter int unsigned REG_AW      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        pin_a,
   output logic [REG_AW-1:0] rf_addr,
   output logic [7:0]        rf_wdata,
   output logic              rf_we,
   input  logic [7:0]        rf_rdata
);

   if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
      $error("i2c_ptr_target: REG_AW must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_ptr_target: SYNC_STAGES must be at least 2");
   end

   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_p, stop_p;
   logic       matched;
   logic [1:0] line_q;

   i2c_ptr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (line_q)
   );

   assign scl_s = line_q[1];
   assign sda_s = line_q[0];

   i2c_ptr_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   i2c_ptr_engine #(.DEV_HI(DEV_HI), .REG_AW(REG_AW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .sda_s    (sda_s),
      .pin_a    (pin_a),
      .rf_rdata (rf_rdata),
      .sda_oe   (sda_oe),
      .ptr      (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_we    (rf_we),
      .matched  (matched)
   );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk #(
   parameter int unsigned REG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_p,
   input logic              stop_p,
   input logic              matched,
   input logic              sda_oe,
   input logic              rf_we,
   input logic [REG_AW-1:0] rf_addr
);

   // R5
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R5
   we_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !scl_s);

   // R5
   we_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $stable(rf_addr));

   // R3
   oe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> matched);

   // R7
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R9
   oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_oe && !matched);

   // R10
   oe_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe && !matched);

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.REG_AW(REG_AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_s),
   .start_p (start_p),
   .stop_p  (stop_p),
   .matched (matched),
   .sda_oe  (sda_oe),
   .rf_we   (rf_we),
   .rf_addr (rf_addr)
);

// File: tb/test_i2c_ptr_target.sv
module test_i2c_ptr_target;

   localparam int AW = 4;
   localparam int NREG = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          quiet = 1'b0;
   logic [1:0]    pin_a = 2'b10;
   logic          sda_oe, rf_we;
   logic [AW-1:0] rf_addr;
   logic [7:0]    rf_wdata, rf_rdata;
   logic          sda_bus;

   logic [7:0]    mem [NREG];
   logic [7:0]    exp_mem [NREG];
   logic [AW-1:0] exp_ptr;
   logic [AW+7:0] wq [$];

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_bus  = sda_m & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   i2c_ptr_target #(.REG_AW(AW)) i_i2c_ptr_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .pin_a    (pin_a),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_we    (rf_we),
      .rf_rdata (rf_rdata)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
      end
   endtask

   // bench register file, written through the block's strobe
   always @(posedge clk) if (rst_n && rf_we) mem[rf_addr] <= rf_wdata;

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (quiet) chk(!sda_oe, "R3/R8 silent line", sda_oe, 0);
         if (rf_we) begin
            if (wq.size() == 0) chk(1'b0, "R6 unexpected write", {rf_addr, rf_wdata}, 0);
            else begin
               logic [AW+7:0] e;
               e = wq.pop_front();
               chk({rf_addr, rf_wdata} == e, "R5 write addr/data", {rf_addr, rf_wdata}, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic slot(input logic drv, input logic mo, output logic seen);
      @(negedge clk); scl_m = 1'b0; quiet = 1'b0;
      repeat (6) @(negedge clk); quiet = mo; sda_m = drv;
      repeat (4) @(negedge clk); scl_m = 1'b1;
      repeat (6) @(negedge clk); seen = sda_bus;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      @(negedge clk); quiet = 1'b1; sda_m = 1'b1;
      repeat (6) @(negedge clk); sda_m = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic bus_rstart();
      @(negedge clk); scl_m = 1'b0; quiet = 1'b0;
      repeat (6) @(negedge clk); quiet = 1'b1; sda_m = 1'b1;
      repeat (4) @(negedge clk); scl_m = 1'b1;
      repeat (6) @(negedge clk); sda_m = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic bus_stop();
      @(negedge clk); scl_m = 1'b0; quiet = 1'b0;
      repeat (6) @(negedge clk); quiet = 1'b1; sda_m = 1'b0;
      repeat (4) @(negedge clk); scl_m = 1'b1;
      repeat (6) @(negedge clk); sda_m = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit ack_exp, input string rq);
      logic s;
      for (int i = 7; i >= 0; i--) slot(b[i], 1'b1, s);
      slot(1'b1, !ack_exp, s);
      chk(s == !ack_exp, rq, s, !ack_exp);
   endtask

   task automatic read_byte(input logic [7:0] expv, input bit m_ack, input string rq);
      logic [7:0] got;
      logic s;
      for (int i = 7; i >= 0; i--) begin
         slot(1'b1, 1'b0, s);
         got[i] = s;
      end
      chk(got == expv, rq, got, expv);
      slot(m_ack ? 1'b0 : 1'b1, 1'b1, s);
   endtask

   task automatic check_state(input string rq);
      chk(rf_addr == exp_ptr, rq, rf_addr, exp_ptr);
      for (int i = 0; i < NREG; i++)
         chk(mem[i] == exp_mem[i], rq, mem[i], exp_mem[i]);
   endtask

   function automatic logic [7:0] dev(input logic [1:0] pins, input logic rw);
      return {5'b01011, pins, rw};
   endfunction

   initial begin
      logic [7:0] extra;
      logic s;
      for (int i = 0; i < NREG; i++) begin
         mem[i] = 8'hA0 + 8'(i);
         exp_mem[i] = 8'hA0 + 8'(i);
      end
      exp_ptr = '0;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(rf_we == 1'b0, "R1 rf_we", rf_we, 0);
      chk(rf_addr == '0, "R1 rf_addr", rf_addr, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 / R4: pointer-only write
      bus_start();
      send_byte(dev(2'b10, 1'b0), 1'b1, "R2 address ack");
      send_byte(8'h07, 1'b1, "R4 pointer ack");
      bus_stop();
      exp_ptr = 4'h7;
      check_state("R4 pointer load");

      // R7 / R8: read at pointer, host NACK
      bus_start();
      send_byte(dev(2'b10, 1'b1), 1'b1, "R2 read address ack");
      read_byte(exp_mem[7], 1'b0, "R7 read data");
      bus_stop();
      check_state("R7 pointer unchanged");

      // R4 / R5: pointer + data, pointer byte truncated to REG_AW bits
      bus_start();
      send_byte(dev(2'b10, 1'b0), 1'b1, "R2 address ack");
      wq.push_back({4'hA, 8'h96});
      send_byte(8'h3A, 1'b1, "R4 pointer ack");
      send_byte(8'h96, 1'b1, "R5 data ack");
      bus_stop();
      exp_ptr = 4'hA; exp_mem[10] = 8'h96;
      check_state("R5 register write");
      chk(wq.size() == 0, "R5 write count", wq.size(), 0);

      // R6: third byte refused
      bus_start();
      send_byte(dev(2'b10, 1'b0), 1'b1, "R2 address ack");
      wq.push_back({4'h2, 8'h11});
      send_byte(8'h02, 1'b1, "R4 pointer ack");
      send_byte(8'h11, 1'b1, "R5 data ack");
      send_byte(8'h22, 1'b0, "R6 surplus byte nack");
      bus_stop();
      exp_ptr = 4'h2; exp_mem[2] = 8'h11;
      check_state("R6 no extra write");

      // R8: host acknowledges, target still sends nothing more
      bus_start();
      send_byte(dev(2'b10, 1'b1), 1'b1, "R2 read address ack");
      read_byte(8'h11, 1'b1, "R7 read written data");
      for (int i = 7; i >= 0; i--) begin
         slot(1'b1, 1'b1, s);
         extra[i] = s;
      end
      chk(extra == 8'hFF, "R8 no second read byte", extra, 8'hFF);
      bus_stop();

      // R3: address mismatch in the fixed bits
      bus_start();
      send_byte({5'b01010, 2'b10, 1'b0}, 1'b0, "R3 mismatch nack");
      send_byte(8'h05, 1'b0, "R3 later byte nack");
      bus_stop();
      check_state("R3 nothing changed");

      // R11: pin-selected bits
      bus_start();
      send_byte(dev(2'b01, 1'b0), 1'b0, "R11 wrong pins nack");
      bus_stop();
      pin_a = 2'b01;
      bus_start();
      send_byte(dev(2'b01, 1'b0), 1'b1, "R11 new pins ack");
      send_byte(8'h04, 1'b1, "R4 pointer ack");
      bus_stop();
      exp_ptr = 4'h4;
      check_state("R11 pointer via new address");
      bus_start();
      send_byte(dev(2'b10, 1'b0), 1'b0, "R11 old pins nack");
      bus_stop();

      // R9: repeated START between pointer write and read
      bus_start();
      send_byte(dev(2'b01, 1'b0), 1'b1, "R2 address ack");
      send_byte(8'h0A, 1'b1, "R4 pointer ack");
      bus_rstart();
      send_byte(dev(2'b01, 1'b1), 1'b1, "R9 read address after restart");
      read_byte(8'h96, 1'b0, "R9 read at new pointer");
      bus_stop();
      exp_ptr = 4'hA;
      check_state("R9 pointer after restart");

      // R10: bytes after STOP without START are ignored
      send_byte(dev(2'b01, 1'b0), 1'b0, "R10 no start nack");
      send_byte(8'h03, 1'b0, "R10 no start later byte");
      bus_stop();
      check_state("R10 nothing changed");
      chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule